// File: doc/BRIEF.md
# ADC Conversion Sequencer with Offset Calibration

This block is the digital controller that sits next to a successive-approximation analog-to-digital converter. Software programs it through four byte-wide register locations. The first is a control register with an enable bit, a start/busy bit, a channel number and a calibrate request. The second is a configuration register that sets the sample (acquisition) length, the conversion-clock divider and how the result is justified. The last two hold the result as a high byte and a low byte.

After a start request the sequencer holds the input in acquisition for the programmed number of conversion-clock periods. It then runs a 10-bit binary search. In that search it drives a trial code to the converter's DAC and reads back a single comparator decision. The comparator, the DAC and the analog multiplexer are outside the block and appear only as ports.

Software can ask for a calibration. The next conversion then runs with every input disconnected, and its result is kept inside the block as an offset. Every later result has that offset subtracted from it, with a floor at zero. A completion flag marks each finished normal conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four register locations read 0x00, `irq_flag` is 0, `ch_connect` and `acq_sample` are 0, and the stored offset is zero.
- R2: The address map is: 0 control, 1 configuration, 2 result high, 3 result low. The control register has enable in bit 0, start/busy in bit 1, channel in bits 5:2 and calibrate in bit 7. The configuration register has format in bit 7, acquisition code in bits 5:3 and divider code in bits 2:0. Bit 6 of both registers reads 0. The conversion-clock period is 2^(divider+1) clock cycles.
- R3: A control write with bit 0 and bit 1 both at 1, made while idle, starts a conversion of the channel in bits 5:2. The bit-1 read stays 1 until the result is written. The result is the largest code C for which the comparator reports input ≥ C. With a nonzero acquisition code of 1..7, busy lasts exactly (A+11)·P clock cycles, where A is 2, 4, 6, 8, 12, 16 or 20 and P is the conversion-clock period.
- R4: With acquisition code 0 there is no acquisition phase. Conversion begins INSTR_CYC clock cycles after the start, so busy lasts INSTR_CYC + 11·P cycles.
- R5: While busy, a control write changes only the enable bit: channel, calibrate and start are ignored. A configuration write is ignored entirely.
- R6: A conversion started with the calibrate bit at 1 keeps `ch_connect` at 0 throughout and stores its result as the offset. It then clears the calibrate bit, leaves both result registers unchanged and does not set `irq_flag`.
- R7: A normal result equals the raw code minus the stored offset, or 0 when the offset is larger than the raw code.
- R8: With format 1, result high = {6'b0, res[9:8]} and result low = res[7:0]. With format 0, result high = res[9:2] and result low = {res[1:0], 6'b0}.
- R9: `irq_flag` goes to 1 when a normal conversion writes its result. It returns to 0 when `irq_clr` is pulsed.
- R10: A control write with bit 0 at 0 aborts any conversion in progress. Busy reads 0 from the next cycle, no result is written, and the stored offset is kept.
- R11: A start request written with bit 0 at 0 does not start a conversion. Busy reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_clr | input | 1 | Clears the completion flag |
| irq_flag | output | 1 | Completion flag for normal conversions |
| dac_code | output | 10 | Trial code driven to the DAC |
| cmp_in | input | 1 | Comparator decision: 1 when input ≥ trial code |
| ch_sel | output | 4 | Analog multiplexer channel |
| ch_connect | output | 1 | Multiplexer connects the selected channel |
| acq_sample | output | 1 | Sample-and-hold is tracking (acquisition phase) |

## Verification
A wrong phase counter or divider shows up as a busy period of the wrong length. The bench measures that length to the exact cycle on every conversion, so such a fault is visible as soon as the first conversion ends. A fault in the binary search or in the offset subtraction corrupts the result bytes that are read right after busy drops. A stray calibration state shows up in several ways: `ch_connect` going high during a dummy run, the calibrate bit failing to clear, or the result registers or `irq_flag` changing when they should hold. All of these can be seen within one conversion of the fault.

// File: rtl/adc_seq_pkg.sv
// Shared constants, sequencer state type and the acquisition-length decode.
// Assumes a 10-bit converter whose result is split over two byte registers.
package adc_seq_pkg;
    localparam int RES_W     = 10;
    localparam int CHAN_W    = 4;
    localparam int ACQ_W     = 3;
    localparam int DIV_W     = 3;
    localparam int ACQ_CNT_W = 5;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_RESH = 2'd2;
    localparam logic [1:0] ADDR_RESL = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DLY  = 2'd1,
        ST_ACQ  = 2'd2,
        ST_CONV = 2'd3
    } seq_state_e;

    // Acquisition code -> conversion-clock periods: 0,2,4,6,8,12,16,20
    function automatic logic [ACQ_CNT_W-1:0] acq_ticks(input logic [ACQ_W-1:0] code);
        if (code <= 3'd4) return {1'b0, code, 1'b0};
        else              return {code, 2'b00} - 5'd8;
    endfunction
endpackage

// File: rtl/adc_seq_clkdiv.sv
// Conversion-clock tick generator.
// Emits a one-cycle tick every 2^(div_code+1) clocks while run is high.
// clr restarts the period so each phase begins on a full period.
// Assumes div_code is held steady while run is high.
module adc_seq_clkdiv #(
    parameter int DIV_CODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  clr,
    input  logic [DIV_CODE_W-1:0] div_code,
    output logic                  tick
);
    localparam int CNT_W = (1 << DIV_CODE_W) + 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Period length for the selected divider code
    always_comb limit = CNT_W'(2) << div_code;

    // Tick on the last count of each period
    always_comb tick = run && (cnt_q == limit - CNT_W'(1));

    // Period counter, restarted by clr or when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) cnt_q <= '0;
        else if (tick)             cnt_q <= '0;
        else                       cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/adc_seq_sar.sv
// Successive-approximation engine.
// start loads the midscale trial code. Each of the next W ticks resolves
// one bit from cmp (1 = input >= trial). Tick W+1 pulses done with the
// final code. clr abandons the search.
// Assumes cmp is valid on the cycle a tick is high.
module adc_seq_sar #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         tick,
    input  logic         cmp,
    output logic [W-1:0] trial,
    output logic         done
);
    localparam int STEP_W = $clog2(W + 1);

    logic              active_q;
    logic [STEP_W-1:0] step_q;
    logic [W-1:0]      code_q;
    logic [W-1:0]      mask;
    logic [W-1:0]      code_nxt;

    // Bit under test this step, and the code after the decision
    always_comb begin
        mask     = {1'b1, {(W-1){1'b0}}} >> step_q;
        code_nxt = (cmp ? code_q : (code_q & ~mask)) | (mask >> 1);
    end

    // Completion strobe on the extra step after the last bit
    always_comb done = active_q && tick && (step_q == STEP_W'(W));

    // Search state: start, step on ticks, finish
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active_q <= 1'b0;
            step_q   <= '0;
            code_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            step_q   <= '0;
            code_q   <= {1'b1, {(W-1){1'b0}}};
        end else if (active_q && tick) begin
            if (step_q < STEP_W'(W)) begin
                code_q <= code_nxt;
                step_q <= step_q + STEP_W'(1);
            end else begin
                active_q <= 1'b0;
            end
        end
    end

    assign trial = code_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion sequencer: register file, phase control and offset store.
// A start request runs either an INSTR_CYC-clock delay (acquisition code
// 0) or an acquisition of N conversion clocks. It then runs the SAR
// search. A calibration run stores its result as an offset. Normal runs
// store raw minus offset, with a floor at zero.
// Assumes the external comparator settles within one clock of a new code.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int INSTR_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic [RES_W-1:0] dac_code,
    input  logic             cmp_in,
    output logic [CHAN_W-1:0] ch_sel,
    output logic             ch_connect,
    output logic             acq_sample
);
    localparam int DLY_W = (INSTR_CYC > 1) ? $clog2(INSTR_CYC) : 1;

    logic              en_q, busy_q, cal_q, fmt_q, irq_q;
    logic [CHAN_W-1:0] chan_q;
    logic [ACQ_W-1:0]  acq_q;
    logic [DIV_W-1:0]  div_q;
    logic [RES_W-1:0]  offset_q, res_q, res_corr;
    seq_state_e        st_q;
    logic [ACQ_CNT_W-1:0] acq_cnt_q;
    logic [DLY_W-1:0]  dly_cnt_q;

    logic ctrl_wr, cfg_wr, start_req, abort, conv_go, div_clr, tick, sar_done;
    logic [RES_W-1:0] sar_code;

    // Write decode: start only from idle; enable low always aborts
    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
        cfg_wr    = wr_en && (wr_addr == ADDR_CFG) && !busy_q;
        start_req = ctrl_wr && !busy_q && wr_data[0] && wr_data[1];
        abort     = ctrl_wr && !wr_data[0];
    end

    // Phase end: entry into the SAR phase
    always_comb begin
        conv_go = !abort &&
                  (((st_q == ST_DLY) && (dly_cnt_q == DLY_W'(INSTR_CYC - 1))) ||
                   ((st_q == ST_ACQ) && tick &&
                    (acq_cnt_q == acq_ticks(acq_q) - ACQ_CNT_W'(1))));
        div_clr = start_req || conv_go || abort;
    end

    // Offset removal with a floor at zero
    always_comb res_corr = (sar_code > offset_q) ? (sar_code - offset_q) : '0;

    adc_seq_clkdiv #(.DIV_CODE_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy_q), .clr(div_clr),
        .div_code(div_q), .tick(tick)
    );

    adc_seq_sar #(.W(RES_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .clr(abort), .start(conv_go),
        .tick(tick), .cmp(cmp_in), .trial(sar_code), .done(sar_done)
    );

    // Registers, phase sequencing and result/offset capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; busy_q <= 1'b0; cal_q <= 1'b0; fmt_q <= 1'b0;
            irq_q <= 1'b0; chan_q <= '0; acq_q <= '0; div_q <= '0;
            offset_q <= '0; res_q <= '0; st_q <= ST_IDLE;
            acq_cnt_q <= '0; dly_cnt_q <= '0;
        end else begin
            if (irq_clr) irq_q <= 1'b0;
            if (ctrl_wr) begin
                en_q <= wr_data[0];
                if (!busy_q) begin
                    chan_q <= wr_data[5:2];
                    cal_q  <= wr_data[7];
                end
            end
            if (cfg_wr) begin
                fmt_q <= wr_data[7];
                acq_q <= wr_data[5:3];
                div_q <= wr_data[2:0];
            end
            if (abort) begin
                busy_q <= 1'b0;
                st_q   <= ST_IDLE;
            end else if (start_req) begin
                busy_q    <= 1'b1;
                st_q      <= (wr_data[0] && acq_q == '0) ? ST_DLY : ST_ACQ;
                acq_cnt_q <= '0;
                dly_cnt_q <= '0;
            end else begin
                unique case (st_q)
                    ST_DLY: begin
                        dly_cnt_q <= dly_cnt_q + DLY_W'(1);
                        if (conv_go) st_q <= ST_CONV;
                    end
                    ST_ACQ: begin
                        if (tick) acq_cnt_q <= acq_cnt_q + ACQ_CNT_W'(1);
                        if (conv_go) st_q <= ST_CONV;
                    end
                    ST_CONV: begin
                        if (sar_done) begin
                            busy_q <= 1'b0;
                            st_q   <= ST_IDLE;
                            if (cal_q) begin
                                offset_q <= sar_code;
                                cal_q    <= 1'b0;
                            end else begin
                                res_q <= res_corr;
                                irq_q <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register read mux with result justification
    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = {cal_q, 1'b0, chan_q, busy_q, en_q};
            ADDR_CFG:  rd_data = {fmt_q, 1'b0, acq_q, div_q};
            ADDR_RESH: rd_data = fmt_q ? {6'b0, res_q[9:8]} : res_q[9:2];
            default:   rd_data = fmt_q ? res_q[7:0] : {res_q[1:0], 6'b0};
        endcase
    end

    assign irq_flag   = irq_q;
    assign dac_code   = sar_code;
    assign ch_sel     = chan_q;
    assign ch_connect = busy_q && !cal_q;
    assign acq_sample = (st_q == ST_ACQ);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Temporal checks on the sequencer, attached to every instance by bind.
// Assumes it observes the top's internal register state read-only.
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       en,
    input logic       cal,
    input logic       irq,
    input logic [9:0] offset,
    input logic [9:0] res
);
    // An enable-low control write stops the sequence on the next cycle
    assert_abort_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && !wr_data[0]) |=> (!busy && !en));

    // The completion flag rises only as a conversion ends
    assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    // The offset changes only at the end of a calibration run
    assert_offset_from_cal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset) |-> ($fell(cal) && $fell(busy)));

    // The result changes only as a conversion ends
    assert_result_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res) |-> $fell(busy));

    // A sequence never runs with the block disabled
    assert_busy_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> en);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy_q), .en(en_q), .cal(cal_q),
    .irq(irq_flag), .offset(offset_q), .res(res_q)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
    localparam int INSTR_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_clr = 1'b0;
    logic       irq_flag;
    logic [9:0] dac_code;
    logic       cmp_in;
    logic [3:0] ch_sel;
    logic       ch_connect;
    logic       acq_sample;

    int total = 0;
    int bad = 0;
    int off_val = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit saw_connect = 1'b0;

    always #2.5 clk = ~clk;

    // Analog model: per-channel level
    function automatic int aval(input int ch);
        return (ch == 3) ? 10 : ((ch * 61 + 97) % 1024);
    endfunction

    assign cmp_in = ((ch_connect ? aval(int'(ch_sel)) : off_val) >= int'(dac_code));

    adc_seq_ctrl #(.INSTR_CYC(INSTR_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_clr(irq_clr), .irq_flag(irq_flag), .dac_code(dac_code),
        .cmp_in(cmp_in), .ch_sel(ch_sel), .ch_connect(ch_connect),
        .acq_sample(acq_sample)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a; #0.5; v = int'(rd_data);
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    // Count clock edges after the start edge until busy reads 0
    task automatic wait_idle(input int already, output int dur);
        int v;
        dur = already;
        saw_connect = 1'b0;
        do begin
            @(posedge clk); #1; dur++;
            if (ch_connect) saw_connect = 1'b1;
            rd(2'd0, v);
        end while (v[1] && dur < 20000);
    endtask

    task automatic convert(input int ch, input bit cal, output int dur);
        wr(2'd0, {cal, 1'b0, 4'(ch), 2'b11});
        wait_idle(0, dur);
    endtask

    task automatic read_res(input bit fmt, output int r);
        int hi, lo;
        rd(2'd2, hi); rd(2'd3, lo);
        r = fmt ? ((hi << 8) | lo) : ((hi << 2) | (lo >> 6));
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, dur, r, hi, lo, last;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check($sformatf("R1 reg%0d", a), v, 0);
        end
        check("R1 irq", int'(irq_flag), 0);
        check("R1 connect", int'(ch_connect), 0);
        check("R1 sample", int'(acq_sample), 0);

        // R2: configuration layout, bit 6 reads 0
        wr(2'd1, 8'hFF);
        rd(2'd1, v);
        check("R2 cfg readback", v, 8'hBF);

        // R3/R8/R9/R4: all channels, right-justified, no acquisition, fastest clock
        wr(2'd1, 8'h80);
        for (int ch = 0; ch < 16; ch++) begin
            convert(ch, 1'b0, dur);
            check($sformatf("R4 duration ch%0d", ch), dur, INSTR_CYC + 11 * 2);
            read_res(1'b1, r);
            check($sformatf("R3 result ch%0d", ch), r, aval(ch));
            rd(2'd2, hi);
            check($sformatf("R8 right hi ch%0d", ch), hi >> 2, 0);
            check($sformatf("R9 irq set ch%0d", ch), int'(irq_flag), 1);
            pulse_irq_clr();
            check($sformatf("R9 irq clr ch%0d", ch), int'(irq_flag), 0);
        end

        // R3/R4: every acquisition code with three dividers
        for (int acq = 0; acq < 8; acq++) begin
            for (int dv = 0; dv < 3; dv++) begin
                int p, n;
                p = 2 << dv;
                n = (acq <= 4) ? 2 * acq : 4 * acq - 8;
                wr(2'd1, {1'b1, 1'b0, 3'(acq), 3'(dv)});
                convert(5, 1'b0, dur);
                if (acq == 0)
                    check($sformatf("R4 dly dv%0d", dv), dur, INSTR_CYC + 11 * p);
                else
                    check($sformatf("R3 acq%0d dv%0d", acq, dv), dur, (n + 11) * p);
                read_res(1'b1, r);
                check($sformatf("R3 result acq%0d dv%0d", acq, dv), r, aval(5));
            end
        end

        // R8: left-justified layout
        wr(2'd1, 8'h00);
        convert(9, 1'b0, dur);
        rd(2'd2, hi); rd(2'd3, lo);
        check("R8 left hi", hi, aval(9) >> 2);
        check("R8 left lo", lo, (aval(9) & 3) << 6);
        wr(2'd1, 8'h80);

        // R11: start with enable low is ignored
        wr(2'd0, 8'h06);
        @(posedge clk); #1;
        rd(2'd0, v);
        check("R11 no start", v, 8'h04);

        // R5: writes while busy
        wr(2'd1, 8'hBA);                       // format 1, acq 7, div 2
        wr(2'd0, {1'b0, 1'b0, 4'd2, 2'b11});
        wr(2'd0, 8'hBF);                       // calibrate, ch 15, go
        wr(2'd1, 8'h00);
        wait_idle(2, dur);
        rd(2'd0, v);
        check("R5 ctrl held", v, {2'b00, 4'd2, 2'b01});
        rd(2'd1, v);
        check("R5 cfg held", v, 8'hBA);
        read_res(1'b1, r);
        check("R5 result ch2", r, aval(2));
        pulse_irq_clr();

        // R6: calibration run
        wr(2'd1, 8'h80);
        off_val = 37;
        read_res(1'b1, last);
        convert(4, 1'b1, dur);
        check("R6 no connect", int'(saw_connect), 0);
        rd(2'd0, v);
        check("R6 cal cleared", v >> 7, 0);
        check("R6 no irq", int'(irq_flag), 0);
        read_res(1'b1, r);
        check("R6 result kept", r, last);

        // R7: offset subtraction and floor
        convert(4, 1'b0, dur);
        read_res(1'b1, r);
        check("R7 corrected ch4", r, aval(4) - 37);
        convert(3, 1'b0, dur);
        read_res(1'b1, r);
        check("R7 floor ch3", r, 0);
        pulse_irq_clr();

        // R10: abort keeps results and offset
        off_val = 0;
        read_res(1'b1, last);
        wr(2'd1, 8'hBA);
        wr(2'd0, {2'b00, 4'd7, 2'b11});
        repeat (20) @(negedge clk);
        wr(2'd0, {2'b00, 4'd7, 2'b00});
        rd(2'd0, v);
        check("R10 busy cleared", (v >> 1) & 1, 0);
        repeat (300) @(negedge clk);
        check("R10 no irq", int'(irq_flag), 0);
        read_res(1'b1, r);
        check("R10 result kept", r, last);
        wr(2'd1, 8'h80);
        convert(7, 1'b0, dur);
        read_res(1'b1, r);
        check("R10 offset kept", r, aval(7) - 37);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule